// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (512 x 8)

This block is the digital slave side of a two-wire serial EEPROM that stores 512 bytes. It oversamples the clock and data lines with the system clock and finds start and stop conditions on them. It decodes a device-select byte whose low bits carry two chip-address bits, a page-select bit and the transfer direction. It then either takes a word address followed by write data, or streams read data from an internal address counter that advances by one after each byte.

Write data is not written into the array as it arrives. It is collected in a 16-entry staging buffer that covers one page. The array only changes when a stop condition closes the transfer. The commit then takes a fixed busy window of `WR_CYCLES` clocks, which stands for the internal write time, and during that window the device does not answer its own address. A write-protect input that is high at the stop discards the staged bytes and leaves the array as it was.

The data line is open-drain. The block reports through `sda_oe_o` when it pulls the line low, and the surrounding pad logic does the pulling.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, no byte is acknowledged until a start condition (data falling while the clock is high) has been seen. Clock pulses with no start before them draw no ACK.
- R2: After reset the block leaves the data line released. A stop condition (data rising while the clock is high) ends the current command, and the bytes that follow are ignored (no ACK) until the next start.
- R3: The device-select byte is sent MSB first. Bits 7:4 must be 1010 and bits 3:2 must equal `chip_sel_i`. Bit 1 is the page-select bit, and bit 0 gives the direction (1 = read, 0 = write). A matching byte is acknowledged and any other byte is not.
- R4: An ACK is a low level driven from the clock fall after the eighth bit until the clock fall after the ninth bit. The slave gives one for a matching device-select byte, for the word address and for every write data byte. At any other time the slave leaves the line released.
- R5: The 9-bit memory address is formed as {page-select bit, 8-bit word address}.
- R6: Staged write data reaches the array only at a stop condition. A repeated start before the stop discards the staged bytes.
- R7: In a write, the low 4 address bits wrap inside the 16-byte page. When more than 16 bytes are sent, the last 16 received are the ones kept.
- R8: Read data is sent MSB first and changes only after a clock fall. After each byte the address advances by one and wraps from 511 to 0.
- R9: When the master leaves the ninth clock of a read byte high (NACK), the read ends and the slave releases the data line.
- R10: If `wp_i` is high at the stop condition, the array does not change and no busy window starts.
- R11: For `WR_CYCLES` clocks after the stop that commits a write, a matching device-select byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| wp_i | input | 1 | Write protect; when high at a stop, the staged write is dropped |
| chip_sel_i | input | 2 | Chip-address bits compared with device-select bits 3:2 |
| sda_oe_o | output | 1 | 1 = pull the data line low |

## Verification
The hardest states to reach from the ports are those where staged data sits in the buffer and is then dropped or only partly kept. These are a repeated start between data bytes and the stop, a page write longer than one page that wraps over its own earlier bytes, and a stop while write protect is high. The bench reaches each of them with full bus transactions. It then reads the affected addresses back through random reads and compares them with a behavioural byte map. A device-select byte sent right after a committing stop probes the busy window. A sequential read that starts at address 511 covers the wrap of the address counter.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int          WORD_W   = 8;
  localparam logic [3:0]  DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } eep_state_e;
endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_s_q, scl_p_q, sda_s_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s_q <= 1'b1;
      scl_p_q <= 1'b1;
      sda_s_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_s_q <= scl_i;
      scl_p_q <= scl_s_q;
      sda_s_q <= sda_i;
      sda_p_q <= sda_s_q;
    end
  end

  assign scl_lvl   = scl_s_q;
  assign sda_lvl   = sda_s_q;
  assign scl_rise  = scl_s_q & ~scl_p_q;
  assign scl_fall  = ~scl_s_q & scl_p_q;
  assign start_det = scl_s_q & scl_p_q & sda_p_q & ~sda_s_q;
  assign stop_det  = scl_s_q & scl_p_q & ~sda_p_q & sda_s_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/eep_stage.sv
module eep_stage #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              any_valid
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [DATA_W-1:0]  dat_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = wr && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[g] <= 1'b0;
      else if (clr) vld_q[g] <= 1'b0;
      else if (hit) vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) dat_q[g] <= wdata;
    end
  end

  assign rdata     = dat_q[ridx];
  assign rvalid    = vld_q[ridx];
  assign any_valid = |vld_q;
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [1:0] chip_sel_i,
  output logic       sda_oe_o
);
  localparam int ADDR_W = WORD_W + 1;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  eep_line_mon u_mon (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_e          st_q, st_n;
  logic [3:0]          bit_q, bit_n;
  logic [WORD_W-1:0]   sh_q, sh_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic                pg_q, pg_n, rd_q, rd_n, mack_q, mack_n, oe_q, oe_n;
  logic [BUSY_W-1:0]   busy_q, busy_n;
  logic [PAGE_W:0]     cidx_q, cidx_n;
  logic [HI_W-1:0]     cpage_q, cpage_n;

  logic                busy, cmt_run, cmt_last, mem_we;
  logic                stg_wr, stg_clr, stg_rvalid, stg_any;
  logic [WORD_W-1:0]   stg_rdata, mem_rdata;

  assign busy     = (busy_q != '0);
  assign cmt_run  = busy && !cidx_q[PAGE_W];
  assign cmt_last = cmt_run && (cidx_q[PAGE_W-1:0] == '1);
  assign mem_we   = cmt_run && stg_rvalid;

  eep_stage #(.IDX_W(PAGE_W), .DATA_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_ni), .clr(stg_clr), .wr(stg_wr),
    .widx(addr_q[PAGE_W-1:0]), .wdata(sh_q),
    .ridx(cidx_q[PAGE_W-1:0]), .rdata(stg_rdata),
    .rvalid(stg_rvalid), .any_valid(stg_any)
  );

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_array (
    .clk(clk), .we(mem_we), .waddr({cpage_q, cidx_q[PAGE_W-1:0]}),
    .wdata(stg_rdata), .raddr(addr_q), .rdata(mem_rdata)
  );

  // next-state logic
  always_comb begin
    st_n    = st_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    addr_n  = addr_q;
    pg_n    = pg_q;
    rd_n    = rd_q;
    mack_n  = mack_q;
    oe_n    = oe_q;
    busy_n  = busy ? busy_q - BUSY_W'(1) : busy_q;
    cidx_n  = cmt_run ? cidx_q + (PAGE_W+1)'(1) : cidx_q;
    cpage_n = cpage_q;
    stg_wr  = 1'b0;
    stg_clr = cmt_last;

    if (start_det) begin
      st_n  = ST_DEV;
      bit_n = '0;
      oe_n  = 1'b0;
      if (!busy) stg_clr = 1'b1;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
      if (!busy && stg_any) begin
        if (wp_i) begin
          stg_clr = 1'b1;
        end else begin
          busy_n  = BUSY_W'(WR_CYCLES);
          cidx_n  = '0;
          cpage_n = addr_q[ADDR_W-1:PAGE_W];
        end
      end
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && !bit_q[3]) begin
            sh_n  = {sh_q[WORD_W-2:0], sda_lvl};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q[3]) begin
            oe_n = 1'b1;
            if (st_q == ST_DEV) begin
              if (sh_q[7:4] == DEV_TYPE && sh_q[3:2] == chip_sel_i && !busy) begin
                st_n = ST_DEV_ACK;
                pg_n = sh_q[1];
                rd_n = sh_q[0];
              end else begin
                st_n = ST_IDLE;
                oe_n = 1'b0;
              end
            end else if (st_q == ST_WADR) begin
              addr_n = {pg_q, sh_q};
              st_n   = ST_WADR_ACK;
            end else begin
              stg_wr = 1'b1;
              addr_n = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
              st_n   = ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK, ST_RACK: begin
          if (st_q == ST_RACK && scl_rise) mack_n = ~sda_lvl;
          if (scl_fall) begin
            bit_n = '0;
            oe_n  = 1'b0;
            if ((st_q == ST_DEV_ACK && rd_q) || (st_q == ST_RACK && mack_q)) begin
              sh_n   = mem_rdata;
              addr_n = addr_q + ADDR_W'(1);
              oe_n   = ~mem_rdata[WORD_W-1];
              st_n   = ST_RDAT;
            end else if (st_q == ST_RACK) begin
              st_n = ST_IDLE;
            end else begin
              st_n = (st_q == ST_DEV_ACK) ? ST_WADR : ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bit_n = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q[3]) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              sh_n = {sh_q[WORD_W-2:0], 1'b0};
              oe_n = ~sh_q[WORD_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      pg_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      busy_q  <= '0;
      cidx_q  <= {1'b1, {PAGE_W{1'b0}}};
      cpage_q <= '0;
    end else begin
      st_q    <= st_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      addr_q  <= addr_n;
      pg_q    <= pg_n;
      rd_q    <= rd_n;
      mack_q  <= mack_n;
      oe_q    <= oe_n;
      busy_q  <= busy_n;
      cidx_q  <= cidx_n;
      cpage_q <= cpage_n;
    end
  end

  assign sda_oe_o = oe_q;

  assert_busy_silent_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> !oe_q) else $error("slave drove SDA during busy window");

  assert_wp_no_commit_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop_det && wp_i && !busy) |=> (busy_q == '0) && !mem_we)
    else $error("write-protected stop started a commit");

  assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det)) else $error("commit began without a stop");

  assert_sda_change_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(oe_q) || $fell(oe_q)) |-> !$past(scl_lvl))
    else $error("SDA drive changed while SCL high");
endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
  localparam int         WR_CYC = 2000;
  localparam logic [1:0] CHIP   = 2'b10;

  logic clk, rst_n, scl, sda_m, wp, sda_oe, sda_line;
  logic may_drive, run_chk, done;
  int   checks, errors;
  logic [7:0] model [int];

  assign sda_line = sda_m & ~sda_oe;

  serial_eeprom_slave #(.PAGE_W(4), .WR_CYCLES(WR_CYC)) u_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .chip_sel_i(CHIP), .sda_oe_o(sda_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every clock: slave may only pull SDA inside an ACK or read-data window (R4, R8)
  always @(negedge clk) begin
    if (run_chk) begin
      checks++;
      if (sda_oe && !may_drive) begin
        errors++;
        $display("FAIL R4 drive outside window actual=1 expected=0");
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    wt(6);  sda_m = b;
    wt(10); scl = 1'b1;
    wt(8);  s = sda_line;
    wt(8);  scl = 1'b0;
  endtask

  task automatic do_start;
    sda_m = 1'b1; wt(8);
    scl = 1'b1;   wt(8);
    sda_m = 1'b0; wt(8);
    scl = 1'b0;
  endtask

  task automatic do_stop;
    sda_m = 1'b0; wt(8);
    scl = 1'b1;   wt(8);
    sda_m = 1'b1; wt(16);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit keep, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    may_drive = 1'b1;
    clk_bit(1'b1, s);
    ack = !s;
    if (!keep) begin
      wt(5);
      may_drive = 1'b0;
    end
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    logic s;
    may_drive = 1'b1;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    wt(3);
    may_drive = 1'b0;
    clk_bit(mack ? 1'b0 : 1'b1, s);
    sda_m = 1'b1;
    may_drive = mack;
  endtask

  function automatic logic [7:0] dev_byte(input int a, input bit rd);
    logic [8:0] a9;
    a9 = a[8:0];
    return {4'b1010, CHIP, a9[8], rd};
  endfunction

  task automatic write_page(input int a, input int n, input logic [7:0] seed);
    bit ack;
    logic [7:0] v;
    do_start;
    send_byte(dev_byte(a, 1'b0), 1'b0, ack);
    chk(ack, "R3 write select ack", ack, 1);
    send_byte(a[7:0], 1'b0, ack);
    chk(ack, "R4 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      v = seed + 8'(k);
      send_byte(v, 1'b0, ack);
      chk(ack, "R4 data ack", ack, 1);
      if (!wp) model[(a & 'h1F0) | ((a + k) & 'hF)] = v;
    end
    do_stop;
  endtask

  task automatic read_seq(input int a, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    int ea;
    do_start;
    send_byte(dev_byte(a, 1'b0), 1'b0, ack);
    chk(ack, "R3 select ack before read", ack, 1);
    send_byte(a[7:0], 1'b0, ack);
    chk(ack, "R4 address ack before read", ack, 1);
    do_start;
    send_byte(dev_byte(a, 1'b1), 1'b1, ack);
    chk(ack, "R3 read select ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      ea = (a + k) & 'h1FF;
      read_byte(k != n - 1, d);
      chk(d === model[ea], tag, int'(d), int'(model[ea]));
    end
    wt(4);
    chk(sda_oe == 1'b0, "R9 released after NACK", int'(sda_oe), 0);
    do_stop;
  endtask

  initial begin
    bit ack;
    checks = 0; errors = 0; done = 1'b0;
    run_chk = 1'b0; may_drive = 1'b0;
    scl = 1'b1; sda_m = 1'b1; wp = 1'b0; rst_n = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    run_chk = 1'b1;
    chk(sda_oe == 1'b0, "R2 released after reset", int'(sda_oe), 0);

    // R1: clocked byte with no start first
    scl = 1'b0;
    send_byte(dev_byte(0, 1'b0), 1'b0, ack);
    chk(!ack, "R1 no ack without start", ack, 0);
    scl = 1'b1; wt(16);

    // R3: mismatched chip bits, then wrong device type
    do_start;
    send_byte(8'hA4, 1'b0, ack);
    chk(!ack, "R3 chip mismatch", ack, 0);
    do_stop;
    do_start;
    send_byte(8'hB8, 1'b0, ack);
    chk(!ack, "R3 type mismatch", ack, 0);
    do_stop;

    write_page('h005, 1, 8'h11);
    wt(WR_CYC + 50);
    write_page('h105, 1, 8'h3C);
    // R11: own address ignored right after a committing stop
    do_start;
    send_byte(dev_byte(0, 1'b0), 1'b0, ack);
    chk(!ack, "R11 busy select not acked", ack, 0);
    do_stop;
    wt(WR_CYC + 50);
    read_seq('h005, 1, "R5 page bit 0 data");
    read_seq('h105, 1, "R5 page bit 1 data");

    // R6: staged byte dropped by a repeated start
    write_page('h020, 1, 8'h55);
    wt(WR_CYC + 50);
    do_start;
    send_byte(dev_byte('h020, 1'b0), 1'b0, ack);
    send_byte(8'h20, 1'b0, ack);
    send_byte(8'h77, 1'b0, ack);
    chk(ack, "R6 staged byte acked", ack, 1);
    read_seq('h020, 1, "R6 array unchanged");

    // R10: write protect at stop
    wp = 1'b1;
    write_page('h005, 1, 8'h99);
    wp = 1'b0;
    read_seq('h005, 1, "R10 protected byte kept");

    // R7: 20 bytes into one page from offset 14
    write_page('h00E, 20, 8'h40);
    wt(WR_CYC + 50);
    read_seq('h000, 16, "R7 page wrap data");

    // R8: sequential read across 511 -> 0
    write_page('h1FF, 1, 8'hA5);
    wt(WR_CYC + 50);
    read_seq('h1FF, 3, "R8 sequential wrap data");

    // R2: byte after a stop, without a new start
    scl = 1'b0;
    send_byte(dev_byte(0, 1'b0), 1'b0, ack);
    chk(!ack, "R2 ignored after stop", ack, 0);
    scl = 1'b1; wt(16);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule